// File: doc/BRIEF.md
# Dual-Select 256x4 Static Memory

This block is a synthesizable functional model of a 256-word by 4-bit static memory with separate input and output data buses. Two chip selects of opposite polarity must both be asserted (the active-low one low, the active-high one high) before the part does anything. An active-low write enable chooses between storing and fetching, and an active-low output enable gates the read word onto the outputs. The control pins are decoded into five modes: two deselected modes (one per chip select), output-off, read and write.

Tri-state drivers are not used. The output is a 4-bit word together with a drive-enable bit, and a drive-enable of 0 stands for high impedance. A write is taken on the rising clock edge while the write condition holds. Read data is combinational from the address and the stored array. While a write is in progress the outputs are not driven, but the data word already carries the incoming data. When the write ends, the first read cycle shows the new word with no stale value in between. The array has no reset, so its contents are undefined until written. An asynchronous active-low reset is released through a synchroniser, and until that release completes the part behaves as deselected.

Top module: `dual_sel_sram`

## Requirements
- R1: With `sel_hi` low, `dout_en` is 0, `dout` is 4'h0, and no word is written whatever the other inputs are.
- R2: With `sel_lo_n` high, `dout_en` is 0, `dout` is 4'h0, and no word is written whatever the other inputs are.
- R3: When selected (`sel_lo_n`=0, `sel_hi`=1) with `wr_n`=0 at a rising clock edge, `din` is stored at the word numbered by the 8-bit `addr`, whatever `out_en_n` is.
- R4: During a write, `dout_en` is 0 and `dout` carries `din`, so that the data is already in place when the drive comes back.
- R5: When selected with `wr_n`=1 and `out_en_n`=0, `dout_en` is 1 and `dout` is the stored word at `addr`, following an address change within the same cycle without waiting for a clock edge.
- R6: When selected with `wr_n`=1 and `out_en_n`=1, `dout_en` is 0 and `dout` is 4'h0.
- R7: In the first read cycle after a write to the same address, `dout` equals the word just written. After back-to-back writes to one word, the last write wins.
- R8: While `rst_n` is low, and until two rising edges after it rises, the block acts as deselected: `dout_en` is 0 and writes are ignored.
- R9: Each of the 256 words is independent, so a write to one address leaves every other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| sel_lo_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write enable |
| out_en_n | input | 1 | Active-low output enable |
| dout | output | 4 | Output data word (4'h0 when not driven, except during a write) |
| dout_en | output | 1 | 1 = outputs driven, 0 = high impedance |

## Verification
The write of a word and its presentation on the read path fall into adjacent cycles at the same address. The risk is a stale word or an early drive at that boundary. The bench provokes this by holding the address while it moves `wr_n` from low to high between two edges. It also does this after two writes in a row to one word. It then checks that `dout_en` is 0 through the write and rises exactly in the first read cycle, with `dout` equal to the last word written. A separate case changes `addr` between clock edges during a read, to confirm that the read path does not wait for the clock that takes writes.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [2:0] {
    M_OFF_HI  = 3'd0,
    M_OFF_LO  = 3'd1,
    M_QUIET   = 3'd2,
    M_READ    = 3'd3,
    M_WRITE   = 3'd4
  } dss_mode_t;
endpackage

// File: rtl/dss_rst_sync.sv
module dss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic active
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = 1'b1;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign active = sh_q[STAGES-1];
endmodule

// File: rtl/dss_mode_dec.sv
module dss_mode_dec
  import dss_pkg::*;
(
  input  logic      active,
  input  logic      sel_lo_n,
  input  logic      sel_hi,
  input  logic      wr_n,
  input  logic      out_en_n,
  output dss_mode_t mode
);
  always_comb begin
    if (!active)        mode = M_OFF_HI;
    else if (!sel_hi)   mode = M_OFF_LO;
    else if (sel_lo_n)  mode = M_OFF_HI;
    else if (!wr_n)     mode = M_WRITE;
    else if (out_en_n)  mode = M_QUIET;
    else                mode = M_READ;
  end
endmodule

// File: rtl/dss_array.sv
module dss_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dss_out_stage.sv
module dss_out_stage
  import dss_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  dss_mode_t         mode,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  always_comb begin
    dout_en = 1'b0;
    dout    = '0;
    case (mode)
      M_READ: begin
        dout_en = 1'b1;
        dout    = rdata;
      end
      M_WRITE: dout = wdata;
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_sel_sram.sv
module dual_sel_sram
  import dss_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              wr_n,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              active;
  dss_mode_t         mode;
  logic              wr_en;
  logic [DATA_W-1:0] rdata;

  dss_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active)
  );

  dss_mode_dec u_dec (
    .active   (active),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .wr_n     (wr_n),
    .out_en_n (out_en_n),
    .mode     (mode)
  );

  assign wr_en = (mode == M_WRITE);

  dss_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (din),
    .rdata (rdata)
  );

  dss_out_stage #(.DATA_W(DATA_W)) u_out (
    .mode    (mode),
    .rdata   (rdata),
    .wdata   (din),
    .dout    (dout),
    .dout_en (dout_en)
  );
endmodule

// File: rtl/dual_sel_sram_chk.sv
module dual_sel_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              sel_lo_n,
  input logic              sel_hi,
  input logic              wr_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic picked;
  assign picked = !sel_lo_n && sel_hi;

  // R1
  desel_hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hi |-> (!dout_en && dout == '0));

  // R2
  desel_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lo_n |-> (!dout_en && dout == '0));

  // R4
  write_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && picked && !wr_n) |-> (!dout_en && dout == din));

  // R5
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && picked && wr_n && !out_en_n) |-> dout_en);

  // R6
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (picked && wr_n && out_en_n) |-> (!dout_en && dout == '0));

  // R7
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active && picked && !wr_n) && active && picked && wr_n && !out_en_n
      && addr == $past(addr)) |-> (dout == $past(din)));

  // R8
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !dout_en);
endmodule

bind dual_sel_sram dual_sel_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .active   (active),
  .addr     (addr),
  .din      (din),
  .sel_lo_n (sel_lo_n),
  .sel_hi   (sel_hi),
  .wr_n     (wr_n),
  .out_en_n (out_en_n),
  .dout     (dout),
  .dout_en  (dout_en)
);

// File: tb/dual_sel_sram_test.sv
module dual_sel_sram_test;
  logic       clk;
  logic       rst_n;
  logic [7:0] addr;
  logic [3:0] din;
  logic       sel_lo_n, sel_hi, wr_n, out_en_n;
  logic [3:0] dout;
  logic       dout_en;

  int total = 0;
  int bad   = 0;

  dual_sel_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .wr_n(wr_n), .out_en_n(out_en_n),
    .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {req[3:0], sel_lo_n, sel_hi, wr_n, out_en_n, addr[7:0], din[3:0], exp_en, exp_dout[3:0]}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'h5, 1'b0, 4'h5}, // R3 R4 write, oe low
    {4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'h0, 1'b1, 4'h5}, // R7 first read
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 4'hA, 1'b0, 4'hA}, // R3 oe high ignored
    {4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 4'h0, 1'b1, 4'hA}, // R7
    {4'd9, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'h0, 1'b1, 4'h5}, // R9 other word kept
    {4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'h3, 1'b0, 4'h0}, // R1 write blocked
    {4'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'h0, 1'b1, 4'h5}, // R1 word unchanged
    {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 4'hC, 1'b0, 4'h0}, // R2 write blocked
    {4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'h0, 1'b1, 4'h5}, // R2 word unchanged
    {4'd6, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'h0, 1'b0, 4'h0}, // R6 output off
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 4'hF, 1'b0, 4'hF}, // R4
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 8'h80, 4'h6, 1'b0, 4'h6}, // R4 back to back
    {4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 8'h80, 4'h0, 1'b1, 4'h6}, // R7 last wins
    {4'd9, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 4'h0, 1'b1, 4'hA}, // R9
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 4'h9, 1'b0, 4'h9}, // R3
    {4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 4'h0, 1'b1, 4'h9}  // R5 read
  };

  task automatic chk(input string tag, input logic en, input logic [3:0] d);
    total++;
    if (dout_en !== en || dout !== d) begin
      bad++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
               tag, dout_en, dout, en, d);
    end
  endtask

  task automatic drive(input logic sl, input logic sh, input logic w,
                       input logic o, input logic [7:0] a, input logic [3:0] d);
    sel_lo_n = sl; sel_hi = sh; wr_n = w; out_en_n = o; addr = a; din = d;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'h7);
    @(negedge clk); #3 chk("R8 in reset", 1'b0, 4'h0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 4'h0);
    @(negedge clk); #3 chk("R8 reset read", 1'b0, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    #3 chk("R8 sync 0", 1'b0, 4'h0);
    @(negedge clk); #3 chk("R8 sync 1", 1'b0, 4'h0);
    @(negedge clk); #3 chk("R8 active", 1'b1, dout);

    // store 0x10 = 2 for the reset-ignores-write check
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'h2);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9], VEC[i][8:5]);
      #3 chk($sformatf("R%0d vec%0d", VEC[i][24:21], i), VEC[i][4], VEC[i][3:0]);
      @(negedge clk);
    end

    // R5: address change between edges shows the new word at once
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 4'h0);
    #2 chk("R5 addr ff", 1'b1, 4'hA);
    addr = 8'h00;
    #1 chk("R5 addr 00 mid-cycle", 1'b1, 4'h5);
    @(negedge clk);

    // R8: write attempted during a reset pulse is lost
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'h7);
    rst_n = 1'b0;
    #3 chk("R8 pulse", 1'b0, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'hE);
    #3 chk("R8 write in sync window", 1'b0, 4'h0);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h10, 4'h0);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 4'h0);
    #3 chk("R8 word kept", 1'b1, 4'h2);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule